// File: doc/BRIEF.md
# Grayscale PWM Timing Controller

This block turns per-channel grayscale codes into on/off drive enables for a bank of constant-current outputs. It runs entirely on the grayscale clock. A free-running grayscale counter is compared with each channel's latched code. The channel's enable is high during the part of each display period that the code asks for. The comparison follows either a plain threshold or a scattered pattern that spreads the on-time over many short segments.

Data reaches the block as a parallel image of a common shift register. That image holds a grayscale code and a dot-correction word for every channel, plus a 5-bit mode word. A strobe input `lat` marks the moment to act, and `lat_gs` says whether the strobe carries grayscale data or a new mode word. The mode word decides four things. The display either runs once or repeats. A grayscale strobe either restarts the period and blanks the outputs or leaves them alone. New data enters the working latches either at once or one full period later. The on-time is either contiguous or scattered. A fifth bit selects the short-detection threshold and is only passed out. The serial shift path, the current sinks and the fault comparators live outside this block.

Top module: `gspwm_timer`

## Requirements
- R1: A rising edge of `lat` with `lat_gs` low loads `sr_fc` into the mode word: bit 0 repeat, bit 1 restart-on-write, bit 2 deferred update, bit 3 scattered PWM, bit 4 high detection threshold. `lsd_hi` shows bit 4 from the cycle after that edge. A rising edge with `lat_gs` high leaves the mode word unchanged.
- R2: With bit 3 clear, channel i is on while the counter is below its code. A code of 0 keeps the channel off.
- R3: With bit 3 set, the period is cut into 128 segments of 2^(CW-7) clocks. The counter's top 7 bits are the segment index s and its low bits are the position p. Channel i with code g is on when p < (g >> 7) + (s < (g mod 128) ? 1 : 0).
- R4: With bit 0 clear, the display stops after the counter's last count (2^CW - 1), and every output then stays off.
- R5: With bit 0 set, the counter wraps from 2^CW - 1 to 0 and the PWM pattern repeats.
- R6: With bit 1 set, a grayscale strobe edge forces all outputs off in the following cycle and clears the counter. Counting restarts from 0 one cycle later, and a stopped display runs again.
- R7: With bit 1 clear, a grayscale strobe edge neither clears the counter nor forces outputs off.
- R8: With bit 2 clear, a grayscale strobe edge copies `sr_gs` and `sr_dc` into the working latches at that edge. `dc_lat` shows the new words in the next cycle.
- R9: With bit 2 set, the copy happens on the 2^CW-th clock after the strobe edge, taking `sr_gs` and `sr_dc` as they stand then. Until that clock the old codes and `dc_lat` stay in force.
- R10: Only a rising edge of `lat` acts. Holding `lat` high for several cycles has the effect of a single edge.
- R11: During and after reset every output is 0, the counter is running from 0 and all latches hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gsclk | input | 1 | Grayscale clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lat | input | 1 | Latch strobe, acts on its rising edge |
| lat_gs | input | 1 | High: strobe carries grayscale data; low: strobe loads the mode word |
| sr_gs | input | NCH*CW | Grayscale codes from the shift image, channel 0 in the low bits |
| sr_dc | input | NCH*DCW | Dot-correction words from the shift image, channel 0 in the low bits |
| sr_fc | input | 5 | Mode word from the shift image |
| pwm_on | output | NCH | Per-channel output enable |
| dc_lat | output | NCH*DCW | Latched dot-correction words |
| lsd_hi | output | 1 | Stored detection-threshold select |

## Verification
A wrong counter value or a stale running flag shows on `pwm_on` within one clock. It shows on every channel whose code lies near the counter. The comparison is made on every clock against a bench model, so a one-clock slip at a period edge, at a blanking cycle or at a segment boundary is caught at once. A deferred copy that fires early or late changes `dc_lat` at the wrong clock and is caught on that clock. A mode word latched on the wrong strobe shows first on `lsd_hi`, and on the next period's PWM pattern.

// File: rtl/gspwm_pkg.sv
package gspwm_pkg;
   localparam int FC_W = 5;

   // bit 0 at the bottom: repeat, restart, defer, scatter, threshold
   typedef struct packed {
      logic thr_hi;
      logic scatter;
      logic defer_upd;
      logic restart;
      logic rep_en;
   } mode_t;
endpackage

// File: rtl/gspwm_latch.sv
module gspwm_latch
   import gspwm_pkg::*;
#(
   parameter int NCH = 4,
   parameter int CW  = 16,
   parameter int DCW = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lat,
   input  logic               lat_gs,
   input  logic [NCH*CW-1:0]  sr_gs,
   input  logic [NCH*DCW-1:0] sr_dc,
   input  logic [FC_W-1:0]    sr_fc,
   output mode_t              mode,
   output logic               gs_wr,
   output logic [NCH*CW-1:0]  gs_q,
   output logic [NCH*DCW-1:0] dc_q
);
   localparam logic [CW-1:0] PMAX = {CW{1'b1}};

   logic          lat_d;
   logic          rise;
   logic          mode_wr;
   logic          pend;
   logic [CW-1:0] pcnt;
   logic          copy_now;

   assign rise     = lat & ~lat_d;
   assign gs_wr    = rise & lat_gs;
   assign mode_wr  = rise & ~lat_gs;
   assign copy_now = (gs_wr & ~mode.defer_upd) | (~gs_wr & pend & (pcnt == PMAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_d <= 1'b0;
         mode  <= '0;
      end else begin
         lat_d <= lat;
         if (mode_wr) mode <= mode_t'(sr_fc);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         pcnt <= '0;
      end else if (gs_wr) begin
         pend <= mode.defer_upd;
         pcnt <= '0;
      end else if (pend) begin
         if (pcnt == PMAX) pend <= 1'b0;
         else              pcnt <= pcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gs_q <= '0;
         dc_q <= '0;
      end else if (copy_now) begin
         gs_q <= sr_gs;
         dc_q <= sr_dc;
      end
   end

   p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      gs_wr |=> $stable(mode));
   p_immediate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      gs_wr && !mode.defer_upd |=> dc_q == $past(sr_dc));
   p_deferred_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend && !gs_wr && pcnt != PMAX |=> $stable(dc_q) && $stable(gs_q));
endmodule

// File: rtl/gspwm_counter.sv
module gspwm_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gs_wr,
   input  logic          restart,
   input  logic          rep_en,
   output logic [CW-1:0] cnt,
   output logic          active
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic run;
   logic blank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         run   <= 1'b1;
         blank <= 1'b0;
      end else if (gs_wr && restart) begin
         cnt   <= '0;
         run   <= 1'b1;
         blank <= 1'b1;
      end else if (blank) begin
         blank <= 1'b0;
      end else if (run) begin
         if (cnt == CMAX) begin
            cnt <= '0;
            run <= rep_en;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign active = run & ~blank;

   p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gs_wr && restart |=> cnt == '0 && !active);
   p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gs_wr && restart |=> ##1 (active && cnt == '0));
   p_undisturbed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gs_wr && !restart && active && cnt != CMAX |=> cnt == CW'($past(cnt) + 1'b1));
   p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      active && cnt == CMAX && !rep_en && !(gs_wr && restart) |=> !active);
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active && cnt == CMAX && rep_en && !(gs_wr && restart) |=> active && cnt == '0);
endmodule

// File: rtl/gspwm_cmp.sv
module gspwm_cmp #(
   parameter int NCH      = 4,
   parameter int CW       = 16,
   parameter int SEG_BITS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     cnt,
   input  logic              active,
   input  logic              scatter,
   input  logic [NCH*CW-1:0] gs_q,
   output logic [NCH-1:0]    pwm
);
   localparam int LW = CW - SEG_BITS;

   logic [SEG_BITS-1:0] seg;
   logic [LW-1:0]       pos;

   assign seg = cnt[CW-1 -: SEG_BITS];
   assign pos = cnt[LW-1:0];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [CW-1:0]       code;
      logic [LW-1:0]       coarse;
      logic [SEG_BITS-1:0] fine;
      logic                extra;
      logic [LW:0]         limit;
      logic                on_plain;
      logic                on_scat;

      assign code     = gs_q[i*CW +: CW];
      assign coarse   = code[CW-1 -: LW];
      assign fine     = code[SEG_BITS-1:0];
      assign extra    = seg < fine;
      assign limit    = {1'b0, coarse} + {{LW{1'b0}}, extra};
      assign on_plain = cnt < code;
      assign on_scat  = {1'b0, pos} < limit;
      assign pwm[i]   = active & (scatter ? on_scat : on_plain);

      p_zero_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
         code == '0 |-> !pwm[i]);
      p_full_scatter_r3: assert property (@(posedge clk) disable iff (!rst_n)
         active && scatter && coarse != '0 && pos == '0 |-> pwm[i]);
   end
endmodule

// File: rtl/gspwm_timer.sv
module gspwm_timer
   import gspwm_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int CW       = 16,
   parameter int SEG_BITS = 7,
   parameter int DCW      = 7
) (
   input  logic               gsclk,
   input  logic               rst_n,
   input  logic               lat,
   input  logic               lat_gs,
   input  logic [NCH*CW-1:0]  sr_gs,
   input  logic [NCH*DCW-1:0] sr_dc,
   input  logic [4:0]         sr_fc,
   output logic [NCH-1:0]     pwm_on,
   output logic [NCH*DCW-1:0] dc_lat,
   output logic               lsd_hi
);
   initial begin : g_param_chk
      assert (CW > SEG_BITS) else $error("CW must exceed SEG_BITS");
      assert (NCH > 0)       else $error("NCH must be positive");
      assert (DCW > 0)       else $error("DCW must be positive");
   end

   mode_t             mode;
   logic              gs_wr;
   logic [NCH*CW-1:0] gs_q;
   logic [CW-1:0]     cnt;
   logic              active;

   gspwm_latch #(.NCH(NCH), .CW(CW), .DCW(DCW)) u_latch (
      .clk    (gsclk),
      .rst_n  (rst_n),
      .lat    (lat),
      .lat_gs (lat_gs),
      .sr_gs  (sr_gs),
      .sr_dc  (sr_dc),
      .sr_fc  (sr_fc),
      .mode   (mode),
      .gs_wr  (gs_wr),
      .gs_q   (gs_q),
      .dc_q   (dc_lat)
   );

   gspwm_counter #(.CW(CW)) u_cnt (
      .clk     (gsclk),
      .rst_n   (rst_n),
      .gs_wr   (gs_wr),
      .restart (mode.restart),
      .rep_en  (mode.rep_en),
      .cnt     (cnt),
      .active  (active)
   );

   gspwm_cmp #(.NCH(NCH), .CW(CW), .SEG_BITS(SEG_BITS)) u_cmp (
      .clk     (gsclk),
      .rst_n   (rst_n),
      .cnt     (cnt),
      .active  (active),
      .scatter (mode.scatter),
      .gs_q    (gs_q),
      .pwm     (pwm_on)
   );

   assign lsd_hi = mode.thr_hi;

   p_thr_follow_r1: assert property (@(posedge gsclk) disable iff (!rst_n)
      $rose(lat) && !lat_gs |=> lsd_hi == $past(sr_fc[4]));
endmodule

// File: tb/gspwm_timer_tb.sv
module gspwm_timer_tb;
   localparam int NCH = 4, CW = 10, SEG = 7, DCW = 7;
   localparam int MAXC = (1 << CW) - 1;
   localparam int L = 1 << (CW - SEG);

   logic clk = 1'b0, rst_n = 1'b0, lat = 1'b0, lat_gs = 1'b0;
   logic [NCH*CW-1:0]  sr_gs = '0;
   logic [NCH*DCW-1:0] sr_dc = '0;
   logic [4:0]         sr_fc = '0;
   logic [NCH-1:0]     pwm_on;
   logic [NCH*DCW-1:0] dc_lat;
   logic               lsd_hi;

   always #2 clk = ~clk;

   gspwm_timer #(.NCH(NCH), .CW(CW), .SEG_BITS(SEG), .DCW(DCW)) u_dut (
      .gsclk(clk), .rst_n(rst_n), .lat(lat), .lat_gs(lat_gs),
      .sr_gs(sr_gs), .sr_dc(sr_dc), .sr_fc(sr_fc),
      .pwm_on(pwm_on), .dc_lat(dc_lat), .lsd_hi(lsd_hi));

   int tests = 0, fails = 0;
   bit done = 0;
   string tag = "R11";

   // behavioural reference model
   int m_cnt, m_pcnt;
   bit m_run, m_blank, m_pend, m_latd;
   logic [4:0] m_fc, t_ofc;
   bit t_rise, t_gsw;
   int m_gs[NCH];
   int m_dc[NCH];

   task automatic m_copy();
      for (int i = 0; i < NCH; i++) begin
         m_gs[i] = int'(sr_gs[i*CW +: CW]);
         m_dc[i] = int'(sr_dc[i*DCW +: DCW]);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_run = 1; m_blank = 0; m_pend = 0; m_pcnt = 0;
         m_latd = 0; m_fc = '0;
         for (int i = 0; i < NCH; i++) begin m_gs[i] = 0; m_dc[i] = 0; end
      end else begin
         t_ofc  = m_fc;
         t_rise = lat && !m_latd;
         m_latd = lat;
         t_gsw  = t_rise && lat_gs;
         if (t_rise && !lat_gs) m_fc = sr_fc;
         if (t_gsw && t_ofc[1]) begin
            m_cnt = 0; m_run = 1; m_blank = 1;
         end else if (m_blank) m_blank = 0;
         else if (m_run) begin
            if (m_cnt == MAXC) begin m_cnt = 0; m_run = t_ofc[0]; end
            else m_cnt++;
         end
         if (t_gsw) begin
            if (!t_ofc[2]) begin m_copy(); m_pend = 0; end
            else begin m_pend = 1; m_pcnt = 0; end
         end else if (m_pend) begin
            if (m_pcnt == MAXC) begin m_copy(); m_pend = 0; end
            else m_pcnt++;
         end
      end
   end

   function automatic logic [NCH-1:0] exp_pwm();
      logic [NCH-1:0] v;
      for (int i = 0; i < NCH; i++) begin
         int g, s, p;
         g = m_gs[i]; s = m_cnt / L; p = m_cnt % L;
         if (!m_run || m_blank) v[i] = 1'b0;
         else if (!m_fc[3]) v[i] = (m_cnt < g);
         else v[i] = (p < (g >> SEG) + ((s < (g % 128)) ? 1 : 0));
      end
      return v;
   endfunction

   function automatic logic [NCH*DCW-1:0] exp_dc();
      logic [NCH*DCW-1:0] v;
      for (int i = 0; i < NCH; i++) v[i*DCW +: DCW] = DCW'(m_dc[i]);
      return v;
   endfunction

   task automatic check(string t, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
      end
   endtask

   // compared on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({tag, " pwm"}, 64'(pwm_on), 64'(exp_pwm()));
         check({tag, " dc"}, 64'(dc_lat), 64'(exp_dc()));
         check({tag, " thr"}, 64'(lsd_hi), 64'(m_fc[4]));
      end
   end

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic set_gs(int a, int b, int c, int d);
      sr_gs = {CW'(d), CW'(c), CW'(b), CW'(a)};
   endtask

   task automatic program_fc(logic [4:0] v);
      @(negedge clk); sr_fc = v; lat = 1; lat_gs = 0;
      @(negedge clk); lat = 0;
   endtask

   task automatic gs_write(int hold);
      @(negedge clk); lat = 1; lat_gs = 1;
      repeat (hold) @(negedge clk);
      lat = 0; lat_gs = 0;
   endtask

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      check("R11 pwm", 64'(pwm_on), 64'd0);
      check("R11 dc", 64'(dc_lat), 64'd0);
      check("R11 thr", 64'(lsd_hi), 64'd0);
      rst_n = 1;
      run(2);

      // R1: repeat + restart + threshold high, plain PWM
      tag = "R1";
      program_fc(5'b10011);
      check("R1 thr", 64'(lsd_hi), 64'd1);

      // R8 then R2 / R5
      tag = "R8";
      set_gs(0, 1, 300, 1023);
      sr_dc = {7'd9, 7'd100, 7'd33, 7'd5};
      gs_write(1);
      check("R8 dc", 64'(dc_lat), 64'({7'd9, 7'd100, 7'd33, 7'd5}));
      tag = "R2"; run(600);
      tag = "R5"; run(1500);

      // R3: scattered PWM
      tag = "R3";
      program_fc(5'b11011);
      set_gs(5, 129, 700, 1023);
      gs_write(1);
      run(2100);

      // R7: no restart, strobe mid-period
      program_fc(5'b01001);
      run(200);
      tag = "R7";
      set_gs(3, 400, 1000, 64);
      gs_write(1);
      check("R7 pwm", 64'(pwm_on), 64'(exp_pwm()));
      run(300);

      // R6: blanking and resume
      tag = "R6";
      program_fc(5'b00011);
      set_gs(1023, 1023, 1023, 1023);
      gs_write(1);
      run(50);
      gs_write(1);
      check("R6 blank", 64'(pwm_on), 64'd0);
      @(negedge clk);
      check("R6 resume", 64'(pwm_on), 64'hF);

      // R10: strobe held high
      tag = "R10";
      run(100);
      set_gs(0, 2, 9, 1023);
      gs_write(5);
      check("R10 held", 64'(pwm_on[3]), 64'd1);
      run(100);

      // R9: deferred update
      tag = "R9";
      program_fc(5'b00111);
      set_gs(800, 100, 50, 600);
      sr_dc = {7'd1, 7'd2, 7'd3, 7'd4};
      gs_write(1);
      run(1023);
      check("R9 old dc", 64'(dc_lat), 64'({7'd9, 7'd100, 7'd33, 7'd5}));
      @(negedge clk);
      check("R9 new dc", 64'(dc_lat), 64'({7'd1, 7'd2, 7'd3, 7'd4}));
      run(300);

      // R4: one-shot display
      tag = "R4";
      program_fc(5'b00010);
      set_gs(1023, 1023, 1023, 1023);
      gs_write(1);
      run(1100);
      check("R4 stopped", 64'(pwm_on), 64'd0);
      run(300);

      // R1: grayscale strobe must not touch the mode word
      tag = "R1";
      sr_fc = 5'b10000;
      gs_write(1);
      run(2);
      check("R1 hold thr", 64'(lsd_hi), 64'd0);
      finish_run();
   end
endmodule